// File: doc/BRIEF.md
# Test-Port Instruction Register and Decoder

This block holds the instruction of a four-bit test access port. Each instruction bit has a shift flop, and a second row of flops latches the shift contents in parallel. A separate TAP state machine supplies the test clock, the serial input and one indicator for each state. The block uses those indicators to capture, shift and update the instruction. It decodes the latched code into five one-hot selects: drive-from-chain (EXTEST), snapshot/preload, bypass, output-float and hold-pins (CLAMP).

The block also selects which register drives the serial output. During an instruction scan the instruction shift stage drives it. During a data scan the external boundary chain drives it under EXTEST and snapshot/preload. Under every other instruction a one-bit bypass flop, which lives in this block, drives it. The state machine and the boundary cells are outside the block.

Top module: `tap_ir_decode`

## Requirements
- R1: While `tlr_st` is high at a rising `tck`, the latched code becomes 4'b1111, which decodes as bypass (`sel_bypass`=1, all other selects 0).
- R2: A rising `tck` with `cap_ir_st` high loads 4'b0001 into the shift stage. During the following instruction scan, `tdo` therefore shows 1, 0, 0, 0 in that order.
- R3: While `shift_ir_st` is high, each rising `tck` moves the shift stage one place toward bit 0 and enters `tdi` at bit 3. Bit 0 is on `tdo`, so a bit entered on `tdi` appears on `tdo` four shifts later.
- R4: The latched code `ir_code` and the selects change only on a rising `tck` with `upd_ir_st` or `tlr_st` high. Capturing and shifting leave them unchanged.
- R5: Code 4'b0000 asserts `sel_extest`.
- R6: Code 4'b0001 asserts `sel_sample`.
- R7: Code 4'b0100 asserts `sel_hiz`.
- R8: Code 4'b0101 asserts `sel_clamp`.
- R9: Every other code asserts `sel_bypass`. This includes 4'b1111 and any code with bit 1 set.
- R10: Exactly one select is high whenever the latched code is defined.
- R11: While `shift_dr_st` is high and EXTEST or snapshot/preload is selected, `tdo` equals `bsr_so`.
- R12: Under any other instruction, a rising `tck` with `cap_dr_st` high clears the bypass flop. Each data shift then loads `tdi` into it, and `tdo` shows the flop, giving a one-cycle path.
- R13: While `shift_ir_st` is high, `tdo` is the instruction shift stage's bit 0, regardless of the selected instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial test data in |
| tlr_st | input | 1 | Controller is in test-logic-reset |
| cap_ir_st | input | 1 | Controller is in capture-IR |
| shift_ir_st | input | 1 | Controller is in shift-IR |
| upd_ir_st | input | 1 | Controller is in update-IR |
| cap_dr_st | input | 1 | Controller is in capture-DR |
| shift_dr_st | input | 1 | Controller is in shift-DR |
| bsr_so | input | 1 | Serial output of the boundary chain |
| tdo | output | 1 | Selected serial output |
| ir_code | output | 4 | Latched instruction code |
| sel_extest | output | 1 | EXTEST select |
| sel_sample | output | 1 | Snapshot/preload select |
| sel_bypass | output | 1 | Bypass select |
| sel_hiz | output | 1 | Output-float select |
| sel_clamp | output | 1 | Hold-pins select |

## Verification
The assertions assume the state indicators come from a real controller. At most one of them is high in any cycle, and `tlr_st` is high on the first edge, so the latch is defined before anything is decoded. The bench drives the indicators one at a time, in controller order, at the falling edge. It starts with a reset cycle, and it never asserts two indicators together. All sixteen codes are swept, and for each one both the instruction path and the data path are checked.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

    parameter int unsigned IR_W = 4;

    localparam logic [IR_W-1:0] CODE_EXTEST = IR_W'(0);
    localparam logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1);
    localparam logic [IR_W-1:0] CODE_HIZ    = IR_W'(4);
    localparam logic [IR_W-1:0] CODE_CLAMP  = IR_W'(5);
    localparam logic [IR_W-1:0] CODE_RESET  = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] CAP_PATTERN = IR_W'(1);

    typedef struct packed {
        logic extest;
        logic sample;
        logic bypass;
        logic hiz;
        logic clamp;
    } ir_sel_t;

    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic shift_ir;
        logic upd_ir;
        logic cap_dr;
        logic shift_dr;
    } tap_st_t;

    function automatic ir_sel_t decode_ir(input logic [IR_W-1:0] code);
        ir_sel_t s;
        s = '0;
        unique case (code)
            CODE_EXTEST: s.extest = 1'b1;
            CODE_SAMPLE: s.sample = 1'b1;
            CODE_HIZ:    s.hiz    = 1'b1;
            CODE_CLAMP:  s.clamp  = 1'b1;
            default:     s.bypass = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ir_shift_latch.sv
module ir_shift_latch
    import tap_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tdi,
    input  tap_st_t         st,
    output logic [IR_W-1:0] shift_q,
    output logic [IR_W-1:0] latch_q
);

    always_ff @(posedge tck) begin
        if (st.tlr) begin
            shift_q <= CAP_PATTERN;
        end else if (st.cap_ir) begin
            shift_q <= CAP_PATTERN;
        end else if (st.shift_ir) begin
            shift_q <= {tdi, shift_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (st.tlr) begin
            latch_q <= CODE_RESET;
        end else if (st.upd_ir) begin
            latch_q <= shift_q;
        end
    end

    // R1: reset preset of the parallel latch
    a_r1_tlr_preset: assert property (@(posedge tck) st.tlr |=> latch_q == CODE_RESET);
    // R4: latch holds outside update-IR / test-logic-reset
    a_r4_latch_hold: assert property (@(posedge tck) disable iff (st.tlr)
        !st.upd_ir |=> $stable(latch_q));
    // R2: capture loads the fixed pattern
    a_r2_capture: assert property (@(posedge tck) disable iff (st.tlr)
        st.cap_ir |=> shift_q == CAP_PATTERN);
    // R3: shift moves one place toward bit 0
    a_r3_shift: assert property (@(posedge tck) disable iff (st.tlr)
        (st.shift_ir && !st.cap_ir) |=> shift_q[IR_W-2:0] == $past(shift_q[IR_W-1:1]));

endmodule

// File: rtl/ir_decoder.sv
module ir_decoder
    import tap_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tlr,
    input  logic [IR_W-1:0] code,
    output ir_sel_t         sel
);

    always_comb sel = decode_ir(code);

    // R10: selects are one-hot once the latch is defined
    a_r10_onehot: assert property (@(posedge tck) disable iff (tlr)
        $countones(sel) == 1);
    // R9: codes with bit 1 set always land on bypass
    a_r9_bit1_bypass: assert property (@(posedge tck) disable iff (tlr)
        code[1] |-> sel.bypass);

endmodule

// File: rtl/tdo_select.sv
module tdo_select
    import tap_ir_pkg::*;
(
    input  logic    tck,
    input  logic    tdi,
    input  tap_st_t st,
    input  ir_sel_t sel,
    input  logic    ir_so,
    input  logic    bsr_so,
    output logic    tdo
);

    logic bypass_q;
    logic use_chain;

    always_ff @(posedge tck) begin
        if (st.tlr || st.cap_dr) begin
            bypass_q <= 1'b0;
        end else if (st.shift_dr) begin
            bypass_q <= tdi;
        end
    end

    always_comb begin
        use_chain = sel.extest | sel.sample;
        if (st.shift_ir) begin
            tdo = ir_so;
        end else if (use_chain) begin
            tdo = bsr_so;
        end else begin
            tdo = bypass_q;
        end
    end

    // R12: bypass flop clears on capture-DR
    a_r12_bypass_capture: assert property (@(posedge tck) disable iff (st.tlr)
        st.cap_dr |=> !bypass_q);
    // R12: bypass flop takes tdi on each data shift
    a_r12_bypass_shift: assert property (@(posedge tck) disable iff (st.tlr)
        (st.shift_dr && !st.cap_dr) |=> bypass_q == $past(tdi));

endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
    import tap_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tdi,
    input  logic            tlr_st,
    input  logic            cap_ir_st,
    input  logic            shift_ir_st,
    input  logic            upd_ir_st,
    input  logic            cap_dr_st,
    input  logic            shift_dr_st,
    input  logic            bsr_so,
    output logic            tdo,
    output logic [IR_W-1:0] ir_code,
    output logic            sel_extest,
    output logic            sel_sample,
    output logic            sel_bypass,
    output logic            sel_hiz,
    output logic            sel_clamp
);

    tap_st_t         st;
    ir_sel_t         sel;
    logic [IR_W-1:0] shift_q;
    logic [IR_W-1:0] latch_q;

    always_comb begin
        st.tlr      = tlr_st;
        st.cap_ir   = cap_ir_st;
        st.shift_ir = shift_ir_st;
        st.upd_ir   = upd_ir_st;
        st.cap_dr   = cap_dr_st;
        st.shift_dr = shift_dr_st;
    end

    ir_shift_latch u_ir (
        .tck     (tck),
        .tdi     (tdi),
        .st      (st),
        .shift_q (shift_q),
        .latch_q (latch_q)
    );

    ir_decoder u_dec (
        .tck  (tck),
        .tlr  (tlr_st),
        .code (latch_q),
        .sel  (sel)
    );

    tdo_select u_tdo (
        .tck    (tck),
        .tdi    (tdi),
        .st     (st),
        .sel    (sel),
        .ir_so  (shift_q[0]),
        .bsr_so (bsr_so),
        .tdo    (tdo)
    );

    assign ir_code    = latch_q;
    assign sel_extest = sel.extest;
    assign sel_sample = sel.sample;
    assign sel_bypass = sel.bypass;
    assign sel_hiz    = sel.hiz;
    assign sel_clamp  = sel.clamp;

    // R13: instruction scan routes the shift stage to tdo
    a_r13_ir_path: assert property (@(posedge tck) disable iff (tlr_st)
        shift_ir_st |-> tdo == shift_q[0]);
    // R11: data scan under chain instructions routes the boundary chain
    a_r11_chain_path: assert property (@(posedge tck) disable iff (tlr_st)
        (shift_dr_st && !shift_ir_st && (sel_extest || sel_sample)) |-> tdo == bsr_so);

endmodule

// File: tb/tap_ir_decode_tb.sv
module tap_ir_decode_tb;

    logic tck = 1'b0;
    logic tdi = 1'b0, tlr_st = 1'b1, cap_ir_st = 1'b0, shift_ir_st = 1'b0;
    logic upd_ir_st = 1'b0, cap_dr_st = 1'b0, shift_dr_st = 1'b0, bsr_so = 1'b0;
    logic tdo;
    logic [3:0] ir_code;
    logic sel_extest, sel_sample, sel_bypass, sel_hiz, sel_clamp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 tck = ~tck;

    tap_ir_decode u_dut (
        .tck(tck), .tdi(tdi), .tlr_st(tlr_st), .cap_ir_st(cap_ir_st),
        .shift_ir_st(shift_ir_st), .upd_ir_st(upd_ir_st), .cap_dr_st(cap_dr_st),
        .shift_dr_st(shift_dr_st), .bsr_so(bsr_so), .tdo(tdo), .ir_code(ir_code),
        .sel_extest(sel_extest), .sel_sample(sel_sample), .sel_bypass(sel_bypass),
        .sel_hiz(sel_hiz), .sel_clamp(sel_clamp)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_sel(input logic [3:0] c);
        logic ex, sa, hz, cl;
        ex = (c == 4'd0);
        sa = (c == 4'd1);
        hz = (c == 4'd4);
        cl = (c == 4'd5);
        return {ex, sa, ~(ex | sa | hz | cl), hz, cl};
    endfunction

    function automatic logic [4:0] got_sel();
        return {sel_extest, sel_sample, sel_bypass, sel_hiz, sel_clamp};
    endfunction

    task automatic clk1();
        @(posedge tck);
        @(negedge tck);
    endtask

    // capture, shift 8 bits (junk then code), update
    task automatic load_ir(input logic [3:0] code, input logic [3:0] prev);
        logic [3:0] junk;
        junk = ~code ^ 4'b0110;
        cap_ir_st = 1'b1;
        clk1();
        cap_ir_st = 1'b0;
        #1 chk("R4 capture keeps latch", {4'h0, ir_code}, {4'h0, prev});
        shift_ir_st = 1'b1;
        for (int j = 0; j < 8; j++) begin
            tdi = (j < 4) ? junk[j] : code[j-4];
            #1;
            if (j < 4) chk("R2 captured pattern on tdo", {7'd0, tdo}, {7'd0, (j == 0)});
            else       chk("R3 four-shift delay R13", {7'd0, tdo}, {7'd0, junk[j-4]});
            clk1();
        end
        shift_ir_st = 1'b0;
        #1 chk("R4 shift keeps latch", {4'h0, ir_code}, {4'h0, prev});
        chk("R4 shift keeps selects", {3'd0, got_sel()}, {3'd0, exp_sel(prev)});
        upd_ir_st = 1'b1;
        clk1();
        upd_ir_st = 1'b0;
        #1 chk("R5 R6 R7 R8 R9 decode", {3'd0, got_sel()}, {3'd0, exp_sel(code)});
        chk("R4 update loads code", {4'h0, ir_code}, {4'h0, code});
        chk("R10 one-hot", 8'($countones(got_sel())), 8'd1);
    endtask

    task automatic dr_scan(input logic [3:0] code);
        logic prev;
        logic chain;
        chain = (code == 4'd0) || (code == 4'd1);
        cap_dr_st = 1'b1;
        clk1();
        cap_dr_st = 1'b0;
        shift_dr_st = 1'b1;
        prev = 1'b0;
        for (int j = 0; j < 6; j++) begin
            tdi = 1'((j * 3 + int'(code)) & 1) ^ 1'(j >> 1);
            bsr_so = ~tdi ^ 1'(j & 1);
            #1;
            if (chain) chk("R11 chain path", {7'd0, tdo}, {7'd0, bsr_so});
            else       chk("R12 bypass path", {7'd0, tdo}, {7'd0, prev});
            prev = tdi;
            clk1();
        end
        shift_dr_st = 1'b0;
    endtask

    initial begin
        logic [3:0] prev;
        @(negedge tck);
        clk1();
        tlr_st = 1'b0;
        #1 chk("R1 reset code", {4'h0, ir_code}, 8'h0F);
        chk("R1 reset selects bypass", {3'd0, got_sel()}, 8'b0000_0100);
        prev = 4'hF;
        for (int c = 0; c < 16; c++) begin
            load_ir(4'(c), prev);
            dr_scan(4'(c));
            prev = 4'(c);
        end
        load_ir(4'd0, prev);
        tlr_st = 1'b1;
        clk1();
        tlr_st = 1'b0;
        #1 chk("R1 mid-run reset", {4'h0, ir_code}, 8'h0F);
        chk("R1 mid-run reset selects", {3'd0, got_sel()}, 8'b0000_0100);
        dr_scan(4'hF);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule